// File: doc/BRIEF.md
# Transmit Flush Timer with Send-Immediate Strobe

This block decides when a partly filled transmit buffer should be handed to the host-side packet engine as a short packet. A latency timer counts millisecond ticks while the buffer holds fewer bytes than a full packet. When the programmed number of ticks passes with no buffer activity, the timer raises a flush request. The timeout can be set from 1 to 255 ms and is 16 ms after reset.

A single active-low strobe input has two roles. The block registers an active-low power-enable output, and the strobe follows that output. While power-enable is low, meaning the device is configured and awake, a falling edge on the strobe forces an immediate flush. While power-enable is high, meaning suspended or not configured, the same edge raises a resume request, but only if remote wakeup is enabled. Each request stays high until the packet engine acknowledges it.

Top module: `txflush_ctrl`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `flush_req` and `resume_req` are 0 and `pwren_n` is 1. The timeout is 16 ticks.
- R2: A cycle with `tmo_load`=1 and `tmo_value` from 1 to 255 sets the timeout to that many ticks. A load with `tmo_value`=0 is ignored and the previous timeout is kept.
- R3: With the buffer eligible, `flush_req` rises on the clock edge that samples the Nth `ms_tick` since the last restart, where N is the timeout. This holds for N=1, N=3, N=16 and N=255.
- R4: A cycle with `wr_push`=1 or `pkt_taken`=1 restarts the tick count from zero.
- R5: The buffer is eligible only when 0 < `fill_level` < `pkt_size`. While it is not eligible, the count is held at zero and no timer flush is raised.
- R6: `pwren_n` is a register. It is 0 one edge after `configured`=1 with `suspended`=0 is sampled, and 1 one edge after any other input combination is sampled.
- R7: While `pwren_n`=0, a falling edge on `si_n` sets `flush_req` on the third clock edge after `si_n` goes low. This happens whatever the fill level is. Holding `si_n` low gives only one event.
- R8: While `pwren_n`=1, a falling edge on `si_n` sets `resume_req` on the third edge if `rwake_en`=1. If `rwake_en`=0 it has no effect.
- R9: `flush_req` stays 1 until a `flush_ack`=1 is sampled, and `resume_req` stays 1 until a `resume_ack`=1 is sampled. Each clears on the edge that samples its acknowledge.
- R10: While `flush_req` is pending or `pwren_n`=1, the tick count is held at zero. After an acknowledge, a full timeout must pass before the next timer flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond tick |
| fill_level | input | FILL_W | Bytes held in the transmit buffer |
| pkt_size | input | FILL_W | Full packet size threshold |
| wr_push | input | 1 | A byte entered the buffer |
| pkt_taken | input | 1 | The engine removed a packet |
| tmo_load | input | 1 | Load a new timeout |
| tmo_value | input | TMO_W | Timeout in ticks (0 ignored) |
| configured | input | 1 | Device configured by the host |
| suspended | input | 1 | Bus suspend status |
| rwake_en | input | 1 | Remote wakeup allowed |
| si_n | input | 1 | Asynchronous send-immediate / wakeup strobe, active low |
| flush_ack | input | 1 | Engine accepted the flush request |
| resume_ack | input | 1 | Engine accepted the resume request |
| flush_req | output | 1 | Send a short packet now |
| resume_req | output | 1 | Signal resume on the bus |
| pwren_n | output | 1 | Active-low power enable, high when suspended |

## Verification
A tick count that is off by one, or that is not cleared on a restart, moves the rising edge of `flush_req` by at least one tick period. The scoreboard, which records the exact cycle of every rising request, sees the shift at the first expiry after the fault. A strobe routed by the wrong state, or an edge detector that re-fires on a held level, shows up as a request on the wrong output or as a second rise within a few cycles. A lost hold-until-acknowledge shows up as a request that drops with no acknowledge, and the bench sees this within the cycles it waits before acknowledging.

// File: rtl/txflush_pkg.sv
package txflush_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE  = 2'd0,
    ROUTE_FLUSH = 2'd1,
    ROUTE_WAKE  = 2'd2
  } route_e;

  // Pick where a strobe edge goes, based on the power state.
  function automatic route_e pick_route(input logic edge_seen,
                                        input logic pwr_off,
                                        input logic wake_ok);
    if (!edge_seen)
      return ROUTE_NONE;
    else if (!pwr_off)
      return ROUTE_FLUSH;
    else if (wake_ok)
      return ROUTE_WAKE;
    else
      return ROUTE_NONE;
  endfunction
endpackage

// File: rtl/txflush_strobe_sync.sv
module txflush_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fall
);
  logic [STAGES-1:0] stage;
  logic              last;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= 1'b1;
          else     stage[0] <= strobe_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= 1'b1;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b1;
    else     last <= stage[STAGES-1];
  end

  assign fall = last & ~stage[STAGES-1];
endmodule

// File: rtl/txflush_timer.sv
module txflush_timer #(
  parameter int          FILL_W    = 9,
  parameter int          TMO_W     = 8,
  parameter logic [7:0]  TMO_RESET = 8'd16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic [FILL_W-1:0] fill_level,
  input  logic [FILL_W-1:0] pkt_size,
  input  logic              restart,
  input  logic              hold,
  input  logic              tmo_load,
  input  logic [TMO_W-1:0]  tmo_value,
  output logic              expire
);
  localparam int CW = TMO_W + 1;

  logic [TMO_W-1:0] tmo;
  logic [TMO_W-1:0] cnt;
  logic             armed;
  logic             at_limit;

  always_ff @(posedge clk) begin
    if (rst)
      tmo <= TMO_W'(TMO_RESET);
    else if (tmo_load && (tmo_value != '0))
      tmo <= tmo_value;
  end

  assign armed    = !hold && (fill_level != '0) && (fill_level < pkt_size);
  assign at_limit = ({1'b0, cnt} + CW'(1)) >= {1'b0, tmo};
  assign expire   = armed && !restart && ms_tick && at_limit;

  always_ff @(posedge clk) begin
    if (rst || restart || !armed)
      cnt <= '0;
    else if (ms_tick)
      cnt <= at_limit ? '0 : cnt + TMO_W'(1);
  end
endmodule

// File: rtl/txflush_req_hold.sv
module txflush_req_hold (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic ack,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst)      req <= 1'b0;
    else if (set) req <= 1'b1;
    else if (ack) req <= 1'b0;
  end
endmodule

// File: rtl/txflush_ctrl.sv
module txflush_ctrl
  import txflush_pkg::*;
#(
  parameter int          FILL_W      = 9,
  parameter int          TMO_W       = 8,
  parameter logic [7:0]  TMO_RESET   = 8'd16,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic [FILL_W-1:0] fill_level,
  input  logic [FILL_W-1:0] pkt_size,
  input  logic              wr_push,
  input  logic              pkt_taken,
  input  logic              tmo_load,
  input  logic [TMO_W-1:0]  tmo_value,
  input  logic              configured,
  input  logic              suspended,
  input  logic              rwake_en,
  input  logic              si_n,
  input  logic              flush_ack,
  input  logic              resume_ack,
  output logic              flush_req,
  output logic              resume_req,
  output logic              pwren_n
);
  logic   strobe_fall;
  logic   expire;
  route_e route;

  always_ff @(posedge clk) begin
    if (rst) pwren_n <= 1'b1;
    else     pwren_n <= !(configured && !suspended);
  end

  txflush_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .strobe_n(si_n), .fall(strobe_fall)
  );

  txflush_timer #(.FILL_W(FILL_W), .TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) timer_i (
    .clk(clk), .rst(rst), .ms_tick(ms_tick),
    .fill_level(fill_level), .pkt_size(pkt_size),
    .restart(wr_push | pkt_taken), .hold(flush_req | pwren_n),
    .tmo_load(tmo_load), .tmo_value(tmo_value), .expire(expire)
  );

  assign route = pick_route(strobe_fall, pwren_n, rwake_en);

  txflush_req_hold flush_hold_i (
    .clk(clk), .rst(rst),
    .set(expire || (route == ROUTE_FLUSH)),
    .ack(flush_ack), .req(flush_req)
  );

  txflush_req_hold wake_hold_i (
    .clk(clk), .rst(rst),
    .set(route == ROUTE_WAKE),
    .ack(resume_ack), .req(resume_req)
  );
endmodule

// File: rtl/txflush_ctrl_chk.sv
module txflush_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic configured,
  input logic suspended,
  input logic rwake_en,
  input logic flush_ack,
  input logic resume_ack,
  input logic flush_req,
  input logic resume_req,
  input logic pwren_n
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!flush_req && !resume_req && pwren_n));

  assert_flush_held_R9: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !flush_ack) |=> flush_req);

  assert_resume_held_R9: assert property (@(posedge clk) disable iff (rst)
    (resume_req && !resume_ack) |=> resume_req);

  assert_suspend_off_R6: assert property (@(posedge clk) disable iff (rst)
    suspended |=> pwren_n);

  assert_awake_on_R6: assert property (@(posedge clk) disable iff (rst)
    (configured && !suspended) |=> !pwren_n);

  assert_wake_needs_off_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(resume_req) |-> ($past(pwren_n) && $past(rwake_en)));

  assert_flush_needs_on_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flush_req) |-> !$past(pwren_n));
endmodule

bind txflush_ctrl txflush_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .configured(configured), .suspended(suspended),
  .rwake_en(rwake_en), .flush_ack(flush_ack), .resume_ack(resume_ack),
  .flush_req(flush_req), .resume_req(resume_req), .pwren_n(pwren_n)
);

// File: tb/txflush_ctrl_tb.sv
module txflush_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ms_tick = 0, wr_push = 0, pkt_taken = 0, tmo_load = 0;
  logic [8:0] fill_level = 9'd5, pkt_size = 9'd64;
  logic [7:0] tmo_value = 8'd0;
  logic       configured = 0, suspended = 0, rwake_en = 0, si_n = 1;
  logic       flush_ack = 0, resume_ack = 0;
  logic       flush_req, resume_req, pwren_n;

  int     n_checks = 0, n_fail = 0;
  longint cyc = 0;
  bit     done = 0;

  typedef struct { int kind; longint at; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  txflush_ctrl dut_i (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .fill_level(fill_level),
    .pkt_size(pkt_size), .wr_push(wr_push), .pkt_taken(pkt_taken),
    .tmo_load(tmo_load), .tmo_value(tmo_value), .configured(configured),
    .suspended(suspended), .rwake_en(rwake_en), .si_n(si_n),
    .flush_ack(flush_ack), .resume_ack(resume_ack),
    .flush_req(flush_req), .resume_req(resume_req), .pwren_n(pwren_n)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp_v, cyc);
    end
  endtask

  task automatic expect_ev(input int kind, input longint at, input string tag);
    exp_t e; e.kind = kind; e.at = at; e.tag = tag; sb.push_back(e);
  endtask

  // monitor: every rising request is matched against the scoreboard
  task automatic observe(input int kind);
    exp_t e;
    if (sb.size() == 0) begin
      check(0, "unexpected request kind", kind, -1);
    end else begin
      e = sb.pop_front();
      check(e.kind == kind, e.tag, kind, e.kind);
      check(e.at == cyc, e.tag, cyc, e.at);
    end
  endtask

  logic pf = 0, pr = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (flush_req && !pf)  observe(0);
      if (resume_req && !pr) observe(1);
    end
    pf = flush_req; pr = resume_req;
  end

  task automatic ticks(input int n, input int fire_on, input string tag);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i == fire_on) expect_ev(0, cyc + 1, tag);
      ms_tick = 1;
      @(negedge clk);
      ms_tick = 0;
    end
  endtask

  task automatic load_tmo(input logic [7:0] v);
    @(negedge clk); tmo_load = 1; tmo_value = v;
    @(negedge clk); tmo_load = 0;
  endtask

  task automatic ack_flush(input string tag);
    @(negedge clk); flush_ack = 1;
    @(negedge clk); flush_ack = 0;
    check(flush_req == 1'b0, tag, flush_req, 0);
  endtask

  task automatic strobe_low(input int kind, input string tag);
    @(negedge clk);
    if (kind >= 0) expect_ev(kind, cyc + 3, tag);
    si_n = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(flush_req == 0 && resume_req == 0, "R1 requests idle", flush_req, 0);
    check(pwren_n == 1, "R1 pwren_n high", pwren_n, 1);
    rst = 0;
    repeat (2) @(negedge clk);
    check(pwren_n == 1, "R6 unconfigured keeps pwren_n high", pwren_n, 1);
    configured = 1;
    @(negedge clk);
    check(pwren_n == 0, "R6 configured drives pwren_n low", pwren_n, 0);

    // R1/R3 default timeout of 16 ticks
    @(negedge clk); wr_push = 1; @(negedge clk); wr_push = 0;
    ticks(16, 16, "R3 default 16 tick expiry");
    repeat (5) @(negedge clk);
    check(flush_req == 1, "R9 flush held without ack", flush_req, 1);
    // R10: ticks while pending do not count
    ticks(3, 0, "R10");
    ack_flush("R9 flush cleared by ack");

    // R2 load 3, then a zero load is ignored
    load_tmo(8'd3);
    ticks(3, 3, "R10 full window after ack; R2 timeout 3");
    ack_flush("R9");
    load_tmo(8'd0);
    ticks(3, 3, "R2 zero load ignored");
    ack_flush("R9");

    // R4 restarts
    ticks(2, 0, "R4");
    @(negedge clk); wr_push = 1; @(negedge clk); wr_push = 0;
    ticks(2, 0, "R4");
    ticks(1, 1, "R4 wr_push restart");
    ack_flush("R9");
    ticks(2, 0, "R4");
    @(negedge clk); pkt_taken = 1; @(negedge clk); pkt_taken = 0;
    ticks(2, 0, "R4");
    ticks(1, 1, "R4 pkt_taken restart");
    ack_flush("R9");

    // R5 eligibility
    fill_level = 9'd0;
    ticks(5, 0, "R5");
    check(flush_req == 0, "R5 empty buffer no flush", flush_req, 0);
    fill_level = 9'd64;
    ticks(5, 0, "R5");
    check(flush_req == 0, "R5 full packet no flush", flush_req, 0);
    fill_level = 9'd63;
    ticks(3, 3, "R5 just below packet size");
    ack_flush("R9");

    // R3 boundary timeouts
    load_tmo(8'd1);
    ticks(1, 1, "R3 timeout 1");
    ack_flush("R9");
    load_tmo(8'd255);
    ticks(255, 255, "R3 timeout 255");
    ack_flush("R9");
    load_tmo(8'd3);

    // R7 send-immediate while awake, held low yields one event
    fill_level = 9'd0;
    strobe_low(0, "R7 strobe flush");
    repeat (6) @(negedge clk);
    ack_flush("R9");
    repeat (4) @(negedge clk);
    check(flush_req == 0, "R7 held low no second event", flush_req, 0);
    si_n = 1;
    repeat (3) @(negedge clk);
    check(resume_req == 0, "R7 no resume while awake", resume_req, 0);

    // R6/R10 suspend
    fill_level = 9'd5;
    suspended = 1;
    @(negedge clk);
    check(pwren_n == 1, "R6 suspend raises pwren_n", pwren_n, 1);
    ticks(5, 0, "R10");
    check(flush_req == 0, "R10 timer halted in suspend", flush_req, 0);

    // R8 wakeup
    strobe_low(-1, "R8");
    repeat (6) @(negedge clk);
    check(resume_req == 0, "R8 wake disabled ignored", resume_req, 0);
    si_n = 1;
    repeat (3) @(negedge clk);
    rwake_en = 1;
    strobe_low(1, "R8 resume request");
    repeat (6) @(negedge clk);
    check(resume_req == 1, "R9 resume held", resume_req, 1);
    @(negedge clk); resume_ack = 1; @(negedge clk); resume_ack = 0;
    check(resume_req == 0, "R9 resume cleared by ack", resume_req, 0);
    repeat (4) @(negedge clk);
    check(resume_req == 0, "R8 held low no second event", resume_req, 0);
    si_n = 1;
    check(flush_req == 0, "R8 no flush in suspend", flush_req, 0);

    // back awake, timer resumes from zero
    suspended = 0;
    repeat (2) @(negedge clk);
    check(pwren_n == 0, "R6 resume lowers pwren_n", pwren_n, 0);
    ticks(3, 3, "R10 timer after suspend");
    ack_flush("R9");

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R3 all expected requests seen", sb.size(), 0);
    summary();
  end
endmodule